// File: doc/BRIEF.md
# Operand-Gathering Function Unit Controller

This controller sits between a register file and an execution ALU. When an operation is issued it latches the operation code and its control flags. It then requests each source operand it still needs, one request per source port, and captures each operand in the cycle that port's grant arrives. Grants may come in any order and after any delay. Once every needed operand is in, it offers the operation to the ALU through a valid/ready handshake. It then waits for the ALU's result through a second handshake.

The ALU reports, for each result port, whether that port carries a real result. The controller requests a register-file write only on those ports. It raises a per-port "no write" mask on the others. Result port 1 carries a condition value and is written only when the operation asks for its condition to be recorded. Source operands can also be suppressed, in three ways:
- a per-port skip input;
- a zero flag that forces operand A (port 0) to zero;
- an immediate flag that supplies operand B (port 1) from the issue bus.

The unit reports busy from issue until the last needed write has been granted.

Top module: `opg_unit`

## Requirements
- R1: A source port whose `rd_skip_i` bit is 1 at issue never raises `rd_req_o` for that operation, and its operand presented to the ALU is zero.
- R2: When `zero_a_i` is 1 at issue, source port 0 is not requested and ALU operand 0 is zero.
- R3: When `imm_ok_i` is 1 at issue and port 1 is not skipped, source port 1 is not requested and ALU operand 1 equals `imm_i`. A skip on port 1 takes precedence and gives zero.
- R4: A requesting source port captures `src_data_i` for that port at the clock edge where its request and grant are both high. Its request is low from the following cycle. A grant on a port that is not requesting changes nothing.
- R5: `alu_valid_o` rises only after every needed operand has been captured. While it is high, no read request is pending. It stays high until `alu_ready_i` is seen.
- R6: When the ALU result is taken (`alu_res_valid_i` with `alu_res_ready_o`), each result port whose ok bit is 1 raises `wr_req_o` with its value on `dst_data_o`. Each result port whose ok bit is 0 raises `wr_mask_o` and never requests. The masks hold until the next accepted issue, and a port never shows request and mask together.
- R7: Result port 1 (the condition port) is written only when `rc_i` was 1 at issue. Otherwise its mask is raised even if the ALU marks it ok.
- R8: An operation with every source skipped, for which the ALU reports no valid result, completes without any read or write request.
- R9: `busy_o` is high from the cycle after an accepted issue until the cycle after the last needed write grant. It is never low while a write request is pending. `issue_i` is ignored while `busy_o` is high.
- R10: After reset, `busy_o`, `rd_req_o`, `wr_req_o`, `wr_mask_o`, `alu_valid_o` and `alu_res_ready_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe, accepted when not busy |
| op_i | input | OP_W | Operation code passed to the ALU |
| zero_a_i | input | 1 | Force operand 0 to zero |
| imm_ok_i | input | 1 | Use `imm_i` as operand 1 |
| imm_i | input | DATA_W | Immediate value |
| rc_i | input | 1 | Record condition on result port 1 |
| rd_skip_i | input | N_SRC | Per-source skip, sampled at issue |
| busy_o | output | 1 | Operation in flight |
| rd_req_o | output | N_SRC | Per-source read request |
| rd_gnt_i | input | N_SRC | Per-source read grant |
| src_data_i | input | N_SRC*DATA_W | Source operand data, port i at bits i*DATA_W |
| alu_op_o | output | OP_W | Latched operation code |
| alu_opnd_o | output | N_SRC*DATA_W | Gathered operands |
| alu_valid_o | output | 1 | Operation offered to the ALU |
| alu_ready_i | input | 1 | ALU accepts the operation |
| alu_res_i | input | N_DST*DATA_W | ALU results, port j at bits j*DATA_W |
| alu_res_ok_i | input | N_DST | Per-result valid flags |
| alu_res_valid_i | input | 1 | ALU result available |
| alu_res_ready_o | output | 1 | Controller ready for the result |
| wr_req_o | output | N_DST | Per-result write request |
| wr_gnt_i | input | N_DST | Per-result write grant |
| wr_mask_o | output | N_DST | Per-result "no write" mask |
| dst_data_o | output | N_DST*DATA_W | Result data held for writing |

## Verification
The bench builds the unit with 16-bit data, two result ports and three source ports. The third source has no immediate or zero role, so the skip path is exercised on a port with no other suppression. Grants, ALU readiness, ALU latency and source data change at random every cycle. Grants on idle ports therefore probe the ignore rule, and operands arrive in every order. Directed operations cover the fully masked case, the combined zero and immediate case, a skip overriding the immediate, and a second issue pulse while busy.

// File: rtl/opg_pkg.sv
package opg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATHER,
    ST_LAUNCH,
    ST_COLLECT,
    ST_WRITE
  } opg_state_t;
endpackage

// File: rtl/opg_src_lane.sv
module opg_src_lane #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              need,
  input  logic [DATA_W-1:0] init_val,
  input  logic              gnt,
  input  logic [DATA_W-1:0] data_i,
  output logic              req,
  output logic [DATA_W-1:0] opnd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      opnd <= '0;
    end else if (load) begin
      req  <= need;
      opnd <= init_val;
    end else if (req && gnt) begin
      req  <= 1'b0;
      opnd <= data_i;
    end
  end
endmodule

// File: rtl/opg_dst_lane.sv
module opg_dst_lane #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic              ok,
  input  logic [DATA_W-1:0] res,
  input  logic              gnt,
  output logic              req,
  output logic              none,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      none <= 1'b0;
      data <= '0;
    end else if (clear) begin
      req  <= 1'b0;
      none <= 1'b0;
    end else if (take) begin
      req  <= ok;
      none <= ~ok;
      data <= res;
    end else if (req && gnt) begin
      req  <= 1'b0;
    end
  end
endmodule

// File: rtl/opg_seq.sv
module opg_seq
  import opg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  input  logic gather_done,
  input  logic alu_ready_i,
  input  logic alu_res_valid_i,
  input  logic write_done,
  output logic accept,
  output logic res_take,
  output logic busy_o,
  output logic alu_valid_o,
  output logic alu_res_ready_o
);
  opg_state_t state;

  assign accept   = issue_i && (state == ST_IDLE);
  assign res_take = (state == ST_COLLECT) && alu_res_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      busy_o          <= 1'b0;
      alu_valid_o     <= 1'b0;
      alu_res_ready_o <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_GATHER;
          busy_o <= 1'b1;
        end
        ST_GATHER: if (gather_done) begin
          state       <= ST_LAUNCH;
          alu_valid_o <= 1'b1;
        end
        ST_LAUNCH: if (alu_ready_i) begin
          state           <= ST_COLLECT;
          alu_valid_o     <= 1'b0;
          alu_res_ready_o <= 1'b1;
        end
        ST_COLLECT: if (alu_res_valid_i) begin
          state           <= ST_WRITE;
          alu_res_ready_o <= 1'b0;
        end
        ST_WRITE: if (write_done) begin
          state  <= ST_IDLE;
          busy_o <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opg_unit.sv
module opg_unit #(
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  parameter int N_SRC  = 3,
  parameter int N_DST  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue_i,
  input  logic [OP_W-1:0]         op_i,
  input  logic                    zero_a_i,
  input  logic                    imm_ok_i,
  input  logic [DATA_W-1:0]       imm_i,
  input  logic                    rc_i,
  input  logic [N_SRC-1:0]        rd_skip_i,
  output logic                    busy_o,
  output logic [N_SRC-1:0]        rd_req_o,
  input  logic [N_SRC-1:0]        rd_gnt_i,
  input  logic [N_SRC*DATA_W-1:0] src_data_i,
  output logic [OP_W-1:0]         alu_op_o,
  output logic [N_SRC*DATA_W-1:0] alu_opnd_o,
  output logic                    alu_valid_o,
  input  logic                    alu_ready_i,
  input  logic [N_DST*DATA_W-1:0] alu_res_i,
  input  logic [N_DST-1:0]        alu_res_ok_i,
  input  logic                    alu_res_valid_i,
  output logic                    alu_res_ready_o,
  output logic [N_DST-1:0]        wr_req_o,
  input  logic [N_DST-1:0]        wr_gnt_i,
  output logic [N_DST-1:0]        wr_mask_o,
  output logic [N_DST*DATA_W-1:0] dst_data_o
);
  localparam int ZERO_PORT = 0;
  localparam int IMM_PORT  = 1;
  localparam int COND_PORT = 1;

  logic accept, res_take, gather_done, write_done;
  logic rc_q;
  logic [N_DST-1:0] ok_eff;

  assign gather_done = ~|(rd_req_o & ~rd_gnt_i);
  assign write_done  = ~|(wr_req_o & ~wr_gnt_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rc_q     <= 1'b0;
      alu_op_o <= '0;
    end else if (accept) begin
      rc_q     <= rc_i;
      alu_op_o <= op_i;
    end
  end

  opg_seq u_seq (
    .clk            (clk),
    .rst            (rst),
    .issue_i        (issue_i),
    .gather_done    (gather_done),
    .alu_ready_i    (alu_ready_i),
    .alu_res_valid_i(alu_res_valid_i),
    .write_done     (write_done),
    .accept         (accept),
    .res_take       (res_take),
    .busy_o         (busy_o),
    .alu_valid_o    (alu_valid_o),
    .alu_res_ready_o(alu_res_ready_o)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic              need;
    logic [DATA_W-1:0] init_val;
    if (i == ZERO_PORT) begin : g_zero
      assign need     = ~rd_skip_i[i] & ~zero_a_i;
      assign init_val = '0;
    end else if (i == IMM_PORT) begin : g_imm
      assign need     = ~rd_skip_i[i] & ~imm_ok_i;
      assign init_val = (imm_ok_i && !rd_skip_i[i]) ? imm_i : '0;
    end else begin : g_plain
      assign need     = ~rd_skip_i[i];
      assign init_val = '0;
    end
    opg_src_lane #(.DATA_W(DATA_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .need    (need),
      .init_val(init_val),
      .gnt     (rd_gnt_i[i]),
      .data_i  (src_data_i[i*DATA_W +: DATA_W]),
      .req     (rd_req_o[i]),
      .opnd    (alu_opnd_o[i*DATA_W +: DATA_W])
    );
  end

  for (genvar j = 0; j < N_DST; j++) begin : g_dst
    if (j == COND_PORT) begin : g_cond
      assign ok_eff[j] = alu_res_ok_i[j] & rc_q;
    end else begin : g_res
      assign ok_eff[j] = alu_res_ok_i[j];
    end
    opg_dst_lane #(.DATA_W(DATA_W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .clear(accept),
      .take (res_take),
      .ok   (ok_eff[j]),
      .res  (alu_res_i[j*DATA_W +: DATA_W]),
      .gnt  (wr_gnt_i[j]),
      .req  (wr_req_o[j]),
      .none (wr_mask_o[j]),
      .data (dst_data_o[j*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/opg_chk.sv
module opg_chk #(
  parameter int N_SRC = 3,
  parameter int N_DST = 2,
  parameter int OP_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_i,
  input logic             busy_o,
  input logic             zero_a_i,
  input logic             imm_ok_i,
  input logic [N_SRC-1:0] rd_skip_i,
  input logic [N_SRC-1:0] rd_req_o,
  input logic [N_SRC-1:0] rd_gnt_i,
  input logic             alu_valid_o,
  input logic             alu_ready_i,
  input logic [N_DST-1:0] wr_req_o,
  input logic [N_DST-1:0] wr_mask_o,
  input logic [OP_W-1:0]  alu_op_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_rd
    assert_skip_noreq_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_req_o[i]) |-> $past(issue_i && !busy_o && !rd_skip_i[i]));
    assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_req_o[i] && rd_gnt_i[i]) |=> !rd_req_o[i]);
  end

  assert_zero_noreq_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req_o[0]) |-> $past(!zero_a_i));

  assert_imm_noreq_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req_o[1]) |-> $past(!imm_ok_i));

  assert_launch_gathered_R5: assert property (@(posedge clk) disable iff (rst)
    alu_valid_o |-> (rd_req_o == '0));

  assert_launch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (alu_valid_o && !alu_ready_i) |=> alu_valid_o);

  for (genvar j = 0; j < N_DST; j++) begin : g_wr
    assert_mask_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !(wr_req_o[j] && wr_mask_o[j]));
  end

  assert_busy_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_req_o != '0) |-> busy_o);

  assert_issue_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(alu_op_o));
endmodule

bind opg_unit opg_chk #(.N_SRC(N_SRC), .N_DST(N_DST), .OP_W(OP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .issue_i    (issue_i),
  .busy_o     (busy_o),
  .zero_a_i   (zero_a_i),
  .imm_ok_i   (imm_ok_i),
  .rd_skip_i  (rd_skip_i),
  .rd_req_o   (rd_req_o),
  .rd_gnt_i   (rd_gnt_i),
  .alu_valid_o(alu_valid_o),
  .alu_ready_i(alu_ready_i),
  .wr_req_o   (wr_req_o),
  .wr_mask_o  (wr_mask_o),
  .alu_op_o   (alu_op_o)
);

// File: tb/opg_unit_tb.sv
module opg_unit_tb;
  localparam int W  = 16;
  localparam int OW = 4;
  localparam int NS = 3;
  localparam int ND = 2;
  localparam logic [OW-1:0] OP_ADD = 4'd0;
  localparam logic [OW-1:0] OP_SUB = 4'd1;
  localparam logic [OW-1:0] OP_NONE = 4'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic issue_i = 0, zero_a_i = 0, imm_ok_i = 0, rc_i = 0;
  logic [OW-1:0] op_i = '0;
  logic [W-1:0] imm_i = '0;
  logic [NS-1:0] rd_skip_i = '0, rd_gnt_i = '0, rd_req_o;
  logic [NS*W-1:0] src_data_i = '0, alu_opnd_o;
  logic busy_o, alu_valid_o, alu_res_ready_o;
  logic alu_ready_i = 0, alu_res_valid_i = 0;
  logic [OW-1:0] alu_op_o;
  logic [ND*W-1:0] alu_res_i = '0, dst_data_o;
  logic [ND-1:0] alu_res_ok_i = '0, wr_req_o, wr_gnt_i = '0, wr_mask_o;

  opg_unit #(.DATA_W(W), .OP_W(OW), .N_SRC(NS), .N_DST(ND)) u_dut (.*);

  int checks = 0, errors = 0;
  int rd_cnt[NS];
  logic req_seen[NS];
  logic [W-1:0] cap[NS];
  int wr_cnt[ND];
  logic [W-1:0] wr_val[ND];
  int alu_cnt = 0, bad_busy = 0;
  logic [W-1:0] seen_opnd[NS];
  logic [OW-1:0] seen_op;
  logic pend = 0, res_hs = 0;
  int dly = 0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] alu_fn(logic [OW-1:0] op, logic [W-1:0] a, logic [W-1:0] b);
    return (op == OP_SUB) ? a - b : a + b;
  endfunction

  function automatic logic [W-1:0] cond_fn(logic [W-1:0] v);
    if (v == '0) return 16'd1;
    else if (v[W-1]) return 16'd2;
    else return 16'd4;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NS; i++) begin
        rd_gnt_i[i] = ($urandom % 3) == 0;
        src_data_i[i*W +: W] = W'($urandom);
        if (rd_req_o[i]) req_seen[i] = 1'b1;
        if (rd_req_o[i] && rd_gnt_i[i]) begin
          rd_cnt[i]++;
          cap[i] = src_data_i[i*W +: W];
        end
      end
      for (int j = 0; j < ND; j++) begin
        wr_gnt_i[j] = $urandom % 2;
        if (wr_req_o[j] && wr_gnt_i[j]) begin
          wr_cnt[j]++;
          wr_val[j] = dst_data_o[j*W +: W];
        end
      end
      if (!busy_o && wr_req_o != '0) bad_busy++;
      if (alu_res_valid_i && res_hs) begin
        alu_res_valid_i = 0;
        res_hs = 0;
      end
      alu_ready_i = ($urandom % 2) == 0;
      if (alu_valid_o && alu_ready_i) begin
        alu_cnt++;
        seen_op = alu_op_o;
        for (int i = 0; i < NS; i++) seen_opnd[i] = alu_opnd_o[i*W +: W];
        pend = 1;
        dly = $urandom % 3;
      end else if (pend) begin
        if (dly == 0) begin
          logic [W-1:0] r;
          r = alu_fn(seen_op, seen_opnd[0], seen_opnd[1]);
          alu_res_i = {cond_fn(r), r};
          alu_res_ok_i = (seen_op == OP_NONE) ? 2'b00 : 2'b11;
          alu_res_valid_i = 1;
          pend = 0;
        end else dly--;
      end
      if (alu_res_valid_i && alu_res_ready_o) res_hs = 1;
    end
  end

  task automatic run_op(input logic [OW-1:0] op, input bit za, input bit io, input logic [W-1:0] imm,
                        input bit rc, input logic [NS-1:0] skip, input bit twice);
    logic [W-1:0] ea[NS];
    logic [W-1:0] r;
    bit need[NS];
    bit wexp[ND];
    @(negedge clk);
    while (busy_o) @(negedge clk);
    for (int i = 0; i < NS; i++) begin rd_cnt[i] = 0; req_seen[i] = 0; end
    for (int j = 0; j < ND; j++) wr_cnt[j] = 0;
    alu_cnt = 0;
    issue_i = 1; op_i = op; zero_a_i = za; imm_ok_i = io; imm_i = imm; rc_i = rc; rd_skip_i = skip;
    @(negedge clk);
    if (twice) begin
      op_i = OP_SUB; zero_a_i = ~za; imm_ok_i = ~io; rc_i = ~rc; rd_skip_i = ~skip;
      @(negedge clk);
    end
    issue_i = 0;
    while (busy_o) @(negedge clk);
    for (int i = 0; i < NS; i++) need[i] = !skip[i];
    if (za) need[0] = 0;
    if (io) need[1] = 0;
    for (int i = 0; i < NS; i++) begin
      ea[i] = need[i] ? cap[i] : '0;
      chk(req_seen[i] == need[i], $sformatf("R1/R2/R3 request port %0d", i), W'(req_seen[i]), W'(need[i]));
      chk(rd_cnt[i] == (need[i] ? 1 : 0), $sformatf("R4 capture count port %0d", i), W'(rd_cnt[i]), W'(need[i]));
    end
    if (io && !skip[1]) ea[1] = imm;
    chk(alu_cnt == 1, "R5 launch count", W'(alu_cnt), 16'd1);
    for (int i = 0; i < NS; i++)
      chk(seen_opnd[i] == ea[i], $sformatf("R4 operand port %0d", i), seen_opnd[i], ea[i]);
    r = alu_fn(op, ea[0], ea[1]);
    wexp[0] = (op != OP_NONE);
    wexp[1] = (op != OP_NONE) && rc;
    for (int j = 0; j < ND; j++) begin
      chk(wr_cnt[j] == (wexp[j] ? 1 : 0), $sformatf("R6/R7 write count port %0d", j), W'(wr_cnt[j]), W'(wexp[j]));
      chk(wr_mask_o[j] == !wexp[j], $sformatf("R6 mask port %0d", j), W'(wr_mask_o[j]), W'(!wexp[j]));
    end
    if (wexp[0]) chk(wr_val[0] == r, "R6 result data", wr_val[0], r);
    if (wexp[1]) chk(wr_val[1] == cond_fn(r), "R7 condition data", wr_val[1], cond_fn(r));
    chk(bad_busy == 0, "R9 busy during write", W'(bad_busy), 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy_o, rd_req_o, wr_req_o, wr_mask_o, alu_valid_o, alu_res_ready_o} == '0,
        "R10 reset outputs", 16'd0, 16'd0);
    rst = 0;
    // R8: all sources skipped, no valid result
    run_op(OP_NONE, 0, 0, 16'h0, 1, 3'b111, 0);
    chk(wr_req_o == '0, "R8 no write pending", W'(wr_req_o), 16'd0);
    // R2/R3: zero and immediate together
    run_op(OP_ADD, 1, 1, 16'h0008, 1, 3'b000, 0);
    // R3: skip overrides immediate
    run_op(OP_ADD, 0, 1, 16'h00AA, 1, 3'b010, 0);
    // R7: condition not recorded
    run_op(OP_SUB, 0, 0, 16'h0, 0, 3'b000, 0);
    // R9: second issue pulse while busy is ignored
    run_op(OP_ADD, 0, 1, 16'h0005, 1, 3'b100, 1);
    for (int n = 0; n < 300; n++) begin
      logic [OW-1:0] op;
      op = OW'($urandom % 3);
      run_op(op, $urandom % 2, $urandom % 2, W'($urandom), $urandom % 2, NS'($urandom), ($urandom % 8) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule